// File: doc/BRIEF.md
# Next-PC and Branch-Condition Unit

This purely combinational block picks the address of the next instruction fetch in a single-cycle processor. It receives four things: the current fetch address, the fetched instruction word, the two register-file read values, and two decode flags. One flag says the instruction is a conditional branch. The other says it is an absolute jump. From these it produces a branch-condition flag and the next fetch address.

The comparison used for the condition is chosen by the opcode field of the instruction. Four comparisons are available: operands equal, operands different, first operand at or below zero, and first operand above zero. The two zero tests treat the first operand as a signed number.

The next address comes from one of three candidates:
- the sequential address (current + 4);
- a relative branch target, built from a scaled, sign-extended 16-bit offset;
- an absolute jump target, which keeps the top bits of the current address and replaces the rest with the 26-bit index shifted left by two.

The jump select has priority over the branch select. There is no delay slot, so a redirect applies to the very next fetch. The block has no clock and no reset. Its outputs follow its inputs within the same cycle, so no valid/ready handshake is involved and back-pressure does not apply.

Top module: `nxpc_unit`

## Requirements
- R1: With the jump flag low and no taken branch, `next_pc` equals `pc + 4`.
- R2: With the jump flag high, `next_pc` is built from `pc[31:28]` in the top bits, then `instr[25:0]`, then two zero bits.
- R3: A taken branch gives `next_pc = pc + 4 + (sign-extended instr[15:0] << 2)`. This holds for both positive and negative offsets, including 0x7FFF and 0x8000.
- R4: The opcode is `instr[31:26]`. For opcode 0x04, `cond_met` is 1 exactly when `rs_val == rt_val`.
- R5: For opcode 0x05, `cond_met` is 1 exactly when `rs_val != rt_val`.
- R6: For opcode 0x06, `cond_met` is 1 exactly when `rs_val`, taken as signed, is less than or equal to zero. `rt_val` has no effect.
- R7: For opcode 0x07, `cond_met` is 1 exactly when `rs_val`, taken as signed, is greater than zero. `rt_val` has no effect.
- R8: For every other opcode, including the jump opcode 0x02, `cond_met` is 0. A raised branch flag then gives `pc + 4`.
- R9: A branch is taken only when `is_branch` is high and `cond_met` is 1. A condition that holds while `is_branch` is low still gives `pc + 4`, and `cond_met` still reports it.
- R10: When `is_jump` and a taken branch occur together, `next_pc` is the jump target.
- R11: All address arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc | input | 32 | Address of the current instruction |
| instr | input | 32 | Current instruction word |
| rs_val | input | 32 | First register read value |
| rt_val | input | 32 | Second register read value |
| is_branch | input | 1 | Decode: instruction is a conditional branch |
| is_jump | input | 1 | Decode: instruction is an absolute jump |
| cond_met | output | 1 | Branch condition selected by the opcode holds |
| next_pc | output | 32 | Address of the next fetch |

## Verification
The bench builds the unit with its default parameters:
- 32-bit addresses;
- a 6-bit opcode;
- a 16-bit branch offset;
- a 26-bit jump index.

This leaves a 4-bit region field that jumps keep. With these values the stimulus can reach the signed boundaries of the zero tests (0, -1, the most negative value and +1). It can also reach the extreme offsets 0x7FFF and 0x8000, the full 26-bit jump index, and address wrap at the top of the 32-bit space. Directed loops sweep the second operand while the zero tests are active, to show that it has no effect.

// File: rtl/nxpc_pkg.sv
package nxpc_pkg;
  localparam int OPC_W = 6;

  localparam logic [OPC_W-1:0] OP_JMP = 6'h02;
  localparam logic [OPC_W-1:0] OP_BEQ = 6'h04;
  localparam logic [OPC_W-1:0] OP_BNE = 6'h05;
  localparam logic [OPC_W-1:0] OP_BLZ = 6'h06;
  localparam logic [OPC_W-1:0] OP_BGZ = 6'h07;

  typedef enum logic [2:0] {
    CMP_NONE,
    CMP_EQ,
    CMP_NE,
    CMP_LEZ,
    CMP_GTZ
  } cmp_kind_e;

  function automatic cmp_kind_e cmp_of_opcode(input logic [OPC_W-1:0] op);
    case (op)
      OP_BEQ:  return CMP_EQ;
      OP_BNE:  return CMP_NE;
      OP_BLZ:  return CMP_LEZ;
      OP_BGZ:  return CMP_GTZ;
      default: return CMP_NONE;
    endcase
  endfunction
endpackage

// File: rtl/nxpc_cond_eval.sv
module nxpc_cond_eval
  import nxpc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [OPC_W-1:0] opcode,
  input  logic [XLEN-1:0]  op_a,
  input  logic [XLEN-1:0]  op_b,
  output logic             cond
);
  cmp_kind_e kind;
  logic      eq_ab;
  logic      a_neg;
  logic      a_zero;

  assign kind   = cmp_of_opcode(opcode);
  assign eq_ab  = (op_a == op_b);
  assign a_neg  = op_a[XLEN-1];
  assign a_zero = (op_a == '0);

  always_comb begin
    case (kind)
      CMP_EQ:  cond = eq_ab;
      CMP_NE:  cond = !eq_ab;
      CMP_LEZ: cond = a_neg | a_zero;
      CMP_GTZ: cond = !a_neg & !a_zero;
      default: cond = 1'b0;
    endcase
  end
endmodule

// File: rtl/nxpc_target_gen.sv
module nxpc_target_gen #(
  parameter int XLEN   = 32,
  parameter int IMM_W  = 16,
  parameter int JIDX_W = 26
) (
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] instr,
  output logic [XLEN-1:0] seq_pc,
  output logic [XLEN-1:0] br_pc,
  output logic [XLEN-1:0] jmp_pc
);
  localparam int REGION_W = XLEN - JIDX_W - 2;
  localparam int EXT_W    = XLEN - IMM_W - 2;

  logic [XLEN-1:0] offs;

  assign seq_pc = pc + XLEN'(4);
  assign offs   = {{EXT_W{instr[IMM_W-1]}}, instr[IMM_W-1:0], 2'b00};
  assign br_pc  = seq_pc + offs;

  generate
    if (REGION_W > 0) begin : g_region
      assign jmp_pc = {pc[XLEN-1 -: REGION_W], instr[JIDX_W-1:0], 2'b00};
    end else begin : g_flat
      assign jmp_pc = XLEN'({instr[JIDX_W-1:0], 2'b00});
    end
  endgenerate
endmodule

// File: rtl/nxpc_pc_mux.sv
module nxpc_pc_mux #(
  parameter int XLEN = 32
) (
  input  logic            sel_jmp,
  input  logic            sel_br,
  input  logic [XLEN-1:0] seq_pc,
  input  logic [XLEN-1:0] br_pc,
  input  logic [XLEN-1:0] jmp_pc,
  output logic [XLEN-1:0] next_pc
);
  always_comb begin
    if (sel_jmp)     next_pc = jmp_pc;
    else if (sel_br) next_pc = br_pc;
    else             next_pc = seq_pc;
  end
endmodule

// File: rtl/nxpc_unit.sv
module nxpc_unit
  import nxpc_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int IMM_W  = 16,
  parameter int JIDX_W = 26
) (
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] instr,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  input  logic            is_branch,
  input  logic            is_jump,
  output logic            cond_met,
  output logic [XLEN-1:0] next_pc
);
  localparam int OPC_LSB = XLEN - OPC_W;

  logic [XLEN-1:0] seq_pc, br_pc, jmp_pc;
  logic            take_br;

  nxpc_cond_eval #(.XLEN(XLEN)) u_cond (
    .opcode (instr[XLEN-1:OPC_LSB]),
    .op_a   (rs_val),
    .op_b   (rt_val),
    .cond   (cond_met)
  );

  nxpc_target_gen #(.XLEN(XLEN), .IMM_W(IMM_W), .JIDX_W(JIDX_W)) u_tgt (
    .pc     (pc),
    .instr  (instr),
    .seq_pc (seq_pc),
    .br_pc  (br_pc),
    .jmp_pc (jmp_pc)
  );

  assign take_br = is_branch & cond_met;

  nxpc_pc_mux #(.XLEN(XLEN)) u_mux (
    .sel_jmp (is_jump),
    .sel_br  (take_br),
    .seq_pc  (seq_pc),
    .br_pc   (br_pc),
    .jmp_pc  (jmp_pc),
    .next_pc (next_pc)
  );
endmodule

// File: rtl/nxpc_unit_chk.sv
module nxpc_unit_chk
  import nxpc_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int JIDX_W = 26
) (
  input logic [XLEN-1:0] pc,
  input logic [XLEN-1:0] instr,
  input logic [XLEN-1:0] rs_val,
  input logic [XLEN-1:0] rt_val,
  input logic            is_branch,
  input logic            is_jump,
  input logic            cond_met,
  input logic [XLEN-1:0] next_pc
);
  localparam int RW = XLEN - JIDX_W - 2;
  logic [OPC_W-1:0] op;
  assign op = instr[XLEN-1 -: OPC_W];

  always_comb begin
    // R1 / R9: without jump or taken branch the fetch is sequential
    if (!is_jump && !(is_branch && cond_met))
      a_r1_sequential: assert (next_pc == pc + XLEN'(4));
    // R2 / R10: a jump yields an aligned address inside the current region
    if (is_jump)
      a_r10_jump_wins: assert (next_pc[1:0] == 2'b00 &&
                               next_pc[XLEN-1 -: RW] == pc[XLEN-1 -: RW]);
    if (op == OP_BEQ)
      a_r4_equal: assert (cond_met == (rs_val == rt_val));
    if (op == OP_BNE)
      a_r5_differ: assert (cond_met == (rs_val != rt_val));
    if (op == OP_BLZ)
      a_r6_lez: assert (cond_met == ($signed(rs_val) <= 0));
    if (op == OP_BGZ)
      a_r7_gtz: assert (cond_met == ($signed(rs_val) > 0));
    if (op != OP_BEQ && op != OP_BNE && op != OP_BLZ && op != OP_BGZ)
      a_r8_no_cond: assert (!cond_met);
  end
endmodule

bind nxpc_unit nxpc_unit_chk #(.XLEN(XLEN), .JIDX_W(JIDX_W)) u_chk (
  .pc        (pc),
  .instr     (instr),
  .rs_val    (rs_val),
  .rt_val    (rt_val),
  .is_branch (is_branch),
  .is_jump   (is_jump),
  .cond_met  (cond_met),
  .next_pc   (next_pc)
);

// File: tb/test_nxpc_unit.sv
module test_nxpc_unit;
  logic        clk = 1'b0;
  logic [31:0] pc, instr, rs_val, rt_val, next_pc;
  logic        is_branch, is_jump, cond_met;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  nxpc_unit i_nxpc_unit (
    .pc(pc), .instr(instr), .rs_val(rs_val), .rt_val(rt_val),
    .is_branch(is_branch), .is_jump(is_jump),
    .cond_met(cond_met), .next_pc(next_pc)
  );

  typedef struct packed {
    logic [31:0] v_pc;
    logic [31:0] v_instr;
    logic [31:0] v_rs;
    logic [31:0] v_rt;
    logic        v_br;
    logic        v_jp;
    logic [31:0] e_pc;
    logic        e_c;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VT [NV] = '{
    '{32'h00400000, 32'h00000000, 32'd1, 32'd2, 1'b0, 1'b0, 32'h00400004, 1'b0, 8'd1},  // R1
    '{32'h00400010, 32'h10000003, 32'd5, 32'd5, 1'b1, 1'b0, 32'h00400020, 1'b1, 8'd4},  // R4 taken
    '{32'h00400010, 32'h10000003, 32'd5, 32'd6, 1'b1, 1'b0, 32'h00400014, 1'b0, 8'd4},  // R4 not
    '{32'h00400100, 32'h1000FFFC, 32'd7, 32'd7, 1'b1, 1'b0, 32'h004000F4, 1'b1, 8'd3},  // R3 negative
    '{32'h00001000, 32'h14000001, 32'd1, 32'd2, 1'b1, 1'b0, 32'h00001008, 1'b1, 8'd5},  // R5 taken
    '{32'h00001000, 32'h14000001, 32'd9, 32'd9, 1'b1, 1'b0, 32'h00001004, 1'b0, 8'd5},  // R5 not
    '{32'h00002000, 32'h18000002, 32'd0, 32'h55, 1'b1, 1'b0, 32'h0000200C, 1'b1, 8'd6}, // R6 zero
    '{32'h00002000, 32'h18000002, 32'h80000000, 32'd0, 1'b1, 1'b0, 32'h0000200C, 1'b1, 8'd6}, // R6 min
    '{32'h00002000, 32'h18000002, 32'd1, 32'hFFFFFFFF, 1'b1, 1'b0, 32'h00002004, 1'b0, 8'd6}, // R6 +1
    '{32'h00003000, 32'h1C000010, 32'd1, 32'd0, 1'b1, 1'b0, 32'h00003044, 1'b1, 8'd7},  // R7 +1
    '{32'h00003000, 32'h1C000010, 32'd0, 32'd0, 1'b1, 1'b0, 32'h00003004, 1'b0, 8'd7},  // R7 zero
    '{32'h00003000, 32'h1C000010, 32'hFFFFFFFF, 32'd0, 1'b1, 1'b0, 32'h00003004, 1'b0, 8'd7}, // R7 -1
    '{32'hA0001234, 32'h08000100, 32'd0, 32'd0, 1'b0, 1'b1, 32'hA0000400, 1'b0, 8'd2},  // R2
    '{32'h5FFFFFF0, 32'h0BFFFFFF, 32'd0, 32'd0, 1'b0, 1'b1, 32'h5FFFFFFC, 1'b0, 8'd2},  // R2 full index
    '{32'h00004000, 32'h10000008, 32'd3, 32'd3, 1'b0, 1'b0, 32'h00004004, 1'b1, 8'd9},  // R9
    '{32'h70000000, 32'h10000008, 32'd3, 32'd3, 1'b1, 1'b1, 32'h70000020, 1'b1, 8'd10}, // R10
    '{32'hFFFFFFFC, 32'h00000000, 32'd0, 32'd0, 1'b0, 1'b0, 32'h00000000, 1'b0, 8'd11}, // R11 seq
    '{32'hFFFFFFF8, 32'h10000004, 32'd2, 32'd2, 1'b1, 1'b0, 32'h0000000C, 1'b1, 8'd11}, // R11 branch
    '{32'h00000100, 32'h8C000000, 32'd2, 32'd2, 1'b1, 1'b0, 32'h00000104, 1'b0, 8'd8},  // R8
    '{32'h00000000, 32'h10007FFF, 32'd1, 32'd1, 1'b1, 1'b0, 32'h00020000, 1'b1, 8'd3},  // R3 max
    '{32'h00100000, 32'h10008000, 32'd1, 32'd1, 1'b1, 1'b0, 32'h000E0004, 1'b1, 8'd3}   // R3 min
  };

  task automatic apply(input logic [31:0] p, input logic [31:0] i,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic br, input logic jp);
    @(posedge clk);
    #1;
    pc = p; instr = i; rs_val = a; rt_val = b; is_branch = br; is_jump = jp;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] exp_pc, input logic exp_c);
    checks++;
    if (next_pc !== exp_pc || cond_met !== exp_c) begin
      errors++;
      $display("FAIL %s next_pc=%h cond=%b expected next_pc=%h cond=%b",
               req, next_pc, cond_met, exp_pc, exp_c);
    end
  endtask

  initial begin
    pc = '0; instr = '0; rs_val = '0; rt_val = '0; is_branch = 0; is_jump = 0;
    // Idle state (no reset exists): all-zero inputs give a sequential fetch, R1
    apply(32'h0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0);
    check("R1 idle", 32'h4, 1'b0);

    for (int k = 0; k < NV; k++) begin
      apply(VT[k].v_pc, VT[k].v_instr, VT[k].v_rs, VT[k].v_rt, VT[k].v_br, VT[k].v_jp);
      check($sformatf("R%0d vec%0d", VT[k].req, k), VT[k].e_pc, VT[k].e_c);
    end

    // R6: second operand has no effect on the at-or-below-zero test
    for (int k = 0; k < 4; k++) begin
      apply(32'h0000_8000, 32'h18000001, 32'hFFFF_FFF0, 32'h1111_1111 * k, 1'b1, 1'b0);
      check("R6 rt sweep", 32'h0000_8008, 1'b1);
    end
    // R7: second operand has no effect on the above-zero test
    for (int k = 0; k < 4; k++) begin
      apply(32'h0000_9000, 32'h1C000001, 32'h0000_0000, 32'h2222_2222 * k, 1'b1, 1'b0);
      check("R7 rt sweep", 32'h0000_9004, 1'b0);
    end
    // R8: jump opcode with branch flag high reports no condition
    apply(32'h0000_0040, 32'h08000010, 32'd4, 32'd4, 1'b1, 1'b0);
    check("R8 jump opcode", 32'h0000_0044, 1'b0);
    // R10: jump beats a taken not-equal branch
    apply(32'h3000_0000, 32'h14000002, 32'd1, 32'd2, 1'b1, 1'b1);
    check("R10 jump vs bne", 32'h3000_0008, 1'b1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule